// File: doc/BRIEF.md
# Cascadable Bidirectional Display Data Register

This block holds one serial frame of segment data for a display with two backplanes. Serial bits arrive on a shift clock and move through a 280-stage chain, organised as 140 segment pairs. A parallel shadow register takes a copy of the whole chain when a load strobe arrives. The display drivers read only the shadow register, so a new frame can be shifted in while the current one stays on the glass.

A static select input sets which end of the chain the data enters. The bit that drops off the far end is retimed on the falling edge of the shift clock and sent to a serial output. Together with the shift clock and both load strobes, which pass straight through to the cascade outputs, this lets several devices be chained. The load can be given either as a rising edge on an active-high strobe or as a falling edge on an active-low strobe.

Every external input is sampled on a fast system clock. Edges are detected after a short synchroniser, so the whole block runs in one clock domain.

Top module: `seg_frame_reg`

## Requirements
- R1: While `rst` is high, the shift chain, the shadow register (`frameOut`) and `serOut` are all zero.
- R2: Edges on `shClkIn`, `ldPosIn` and `ldNegIn` that occur while `rst` is high, or that are only left over from levels held across the release of reset, cause no shift and no load.
- R3: With `dirSel` = 0, after 280 rising shift-clock edges the k-th bit shifted in (k = 0 first) sits at stage k, which is `frameOut[k]`. Stage 2(n-1) is element 1 of pair n and stage 2(n-1)+1 is element 2.
- R4: With `dirSel` = 1, after 280 rising shift-clock edges the k-th bit shifted in sits at stage 279-k.
- R5: `serOut` changes only after a falling edge of `shClkIn`. It then takes the value of the exit stage (stage 0 when `dirSel` = 0, stage 279 when `dirSel` = 1), so bits leave in the order they entered. A rising edge alone leaves `serOut` unchanged.
- R6: A rising edge on `ldPosIn` copies all 280 stages into `frameOut`. A falling edge on `ldPosIn` has no effect.
- R7: A falling edge on `ldNegIn` copies all 280 stages into `frameOut`. A rising edge on `ldNegIn` has no effect.
- R8: `frameOut` holds its value while shifting continues, until the next load edge.
- R9: `shClkOut`, `ldPosOut` and `ldNegOut` equal `shClkIn`, `ldPosIn` and `ldNegIn` with no register in the path.
- R10: Each input edge takes effect within SYNC_STAGES+2 `clk` cycles. Edges at least that far apart each produce exactly one shift, capture or load event, and never two in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Asynchronous reset, active high |
| dirSel | input | 1 | Static shift direction select |
| shClkIn | input | 1 | Serial shift clock |
| serIn | input | 1 | Serial data input |
| ldPosIn | input | 1 | Load strobe, acts on its rising edge |
| ldNegIn | input | 1 | Load strobe, acts on its falling edge |
| frameOut | output | 2*PAIRS | Shadow register contents, bit i = stage i |
| serOut | output | 1 | Retimed serial output for the next device |
| shClkOut | output | 1 | Forwarded shift clock |
| ldPosOut | output | 1 | Forwarded active-high load strobe |
| ldNegOut | output | 1 | Forwarded active-low load strobe |

## Verification
Four properties are checked on every cycle:
- the zero state held during reset;
- that the control never raises an event while reset is high;
- that `serOut` and `frameOut` move only in the cycle after a capture or load event from the control;
- that no two events are raised together.

Whether the bits land at the right stages in each direction, whether they leave through `serOut` in entry order half a shift period late, and whether the inactive strobe edges and post-reset leftover levels really do nothing can only be shown by the bench scenarios. Those scenarios compare whole frames and serial streams against patterns computed from the requirements.

// File: rtl/seg_frame_reg_pkg.sv
package seg_frame_reg_pkg;
  // Events from the control to the datapath, plus the sampled data bit.
  typedef struct packed {
    logic shift;   // rising shift-clock edge seen
    logic outCap;  // falling shift-clock edge seen
    logic load;    // active load strobe edge seen
    logic bitIn;   // serial data sampled with the shift clock
  } strobe_t;
endpackage

// File: rtl/seg_frame_reg_ctrl.sv
module seg_frame_reg_ctrl
  import seg_frame_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    shClkIn,
  input  logic    serIn,
  input  logic    ldPosIn,
  input  logic    ldNegIn,
  output strobe_t strb
);
  localparam int NUM_IN = 4;
  localparam int WARM   = SYNC_STAGES + 1;
  localparam int CW     = $clog2(WARM + 1);

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncQ [SYNC_STAGES];
  logic [NUM_IN-1:0] prevQ;
  logic [NUM_IN-1:0] cur;
  logic [CW-1:0]     warmCnt;
  logic              armed;

  assign rawIn = {serIn, ldNegIn, ldPosIn, shClkIn};

  // Synchroniser chain, one stage per generate step.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge rst) begin
          if (rst) syncQ[0] <= '0;
          else     syncQ[0] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge rst) begin
          if (rst) syncQ[g] <= '0;
          else     syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign cur = syncQ[SYNC_STAGES-1];

  // Edge history and warm-up: edges count only once the history holds real input.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prevQ   <= '0;
      warmCnt <= '0;
    end else begin
      prevQ <= cur;
      if (!armed) warmCnt <= warmCnt + CW'(1);
    end
  end

  assign armed = (warmCnt == CW'(WARM));

  always_comb begin
    strb.shift  = armed & cur[0] & ~prevQ[0];
    strb.outCap = armed & ~cur[0] & prevQ[0];
    strb.load   = armed & ((cur[1] & ~prevQ[1]) | (~cur[2] & prevQ[2]));
    strb.bitIn  = cur[3];
  end
endmodule

// File: rtl/seg_frame_reg_data.sv
module seg_frame_reg_data
  import seg_frame_reg_pkg::*;
#(
  parameter int PAIRS = 140
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dirSel,
  input  strobe_t            strb,
  output logic [2*PAIRS-1:0] frameOut,
  output logic               serOut
);
  localparam int W = 2 * PAIRS;

  logic [W-1:0] chainQ;
  logic         exitBit;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      chainQ <= '0;
    end else if (strb.shift) begin
      if (dirSel) chainQ <= {chainQ[W-2:0], strb.bitIn};
      else        chainQ <= {strb.bitIn, chainQ[W-1:1]};
    end
  end

  assign exitBit = dirSel ? chainQ[W-1] : chainQ[0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      serOut   <= 1'b0;
      frameOut <= '0;
    end else begin
      if (strb.outCap) serOut   <= exitBit;
      if (strb.load)   frameOut <= chainQ;
    end
  end
endmodule

// File: rtl/seg_frame_reg.sv
module seg_frame_reg
  import seg_frame_reg_pkg::*;
#(
  parameter int PAIRS       = 140,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dirSel,
  input  logic               shClkIn,
  input  logic               serIn,
  input  logic               ldPosIn,
  input  logic               ldNegIn,
  output logic [2*PAIRS-1:0] frameOut,
  output logic               serOut,
  output logic               shClkOut,
  output logic               ldPosOut,
  output logic               ldNegOut
);
  localparam int W = 2 * PAIRS;

  strobe_t strb;

  seg_frame_reg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .shClkIn (shClkIn),
    .serIn   (serIn),
    .ldPosIn (ldPosIn),
    .ldNegIn (ldNegIn),
    .strb    (strb)
  );

  seg_frame_reg_data #(.PAIRS(PAIRS)) data_i (
    .clk      (clk),
    .rst      (rst),
    .dirSel   (dirSel),
    .strb     (strb),
    .frameOut (frameOut),
    .serOut   (serOut)
  );

  // Cascade forwarding, unregistered.
  assign shClkOut = shClkIn;
  assign ldPosOut = ldPosIn;
  assign ldNegOut = ldNegIn;
endmodule

// File: rtl/seg_frame_reg_chk.sv
module seg_frame_reg_chk #(
  parameter int W = 280
) (
  input logic         clk,
  input logic         rst,
  input logic         shiftEv,
  input logic         capEv,
  input logic         loadEv,
  input logic [W-1:0] frameOut,
  input logic         serOut
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |-> (frameOut == '0 && serOut == 1'b0));

  p_no_event_in_reset_r2: assert property (@(posedge clk)
    rst |-> !(shiftEv || capEv || loadEv));

  p_ser_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(capEv) |-> $stable(serOut));

  p_frame_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(loadEv) |-> $stable(frameOut));

  p_single_event_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({shiftEv, capEv, loadEv}));
endmodule

bind seg_frame_reg seg_frame_reg_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .shiftEv  (strb.shift),
  .capEv    (strb.outCap),
  .loadEv   (strb.load),
  .frameOut (frameOut),
  .serOut   (serOut)
);

// File: tb/seg_frame_reg_tb_top.sv
`timescale 1ns/1ps
module seg_frame_reg_tb_top;
  localparam int PAIRS = 140;
  localparam int W     = 2 * PAIRS;

  logic clk = 1'b0;
  logic rstDrv, dirDrv, shClkDrv, serDrv, ldPosDrv, ldNegDrv;
  logic [W-1:0] frameOut;
  logic serOut, shClkOut, ldPosOut, ldNegOut;

  int checks = 0;
  int failures = 0;

  // Bench-side view of the chain, built from R3/R4 and used for R5 and loads.
  logic [W-1:0] mdl;
  logic         prevSer;
  logic         expQ [$];
  logic [W-1:0] patA, patB, patC, expF, snap;

  always #10 clk = ~clk;   // 50 MHz

  seg_frame_reg #(.PAIRS(PAIRS)) dut_i (
    .clk(clk), .rst(rstDrv), .dirSel(dirDrv), .shClkIn(shClkDrv), .serIn(serDrv),
    .ldPosIn(ldPosDrv), .ldNegIn(ldNegDrv), .frameOut(frameOut), .serOut(serOut),
    .shClkOut(shClkOut), .ldPosOut(ldPosOut), .ldNegOut(ldNegOut)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] mkPat(input logic [31:0] seed);
    logic [31:0] s = seed;
    logic [W-1:0] p;
    for (int k = 0; k < W; k++) begin
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      p[k] = s[0];
    end
    return p;
  endfunction

  task automatic chkFwd();
    #1;
    chk(shClkOut == shClkDrv && ldPosOut == ldPosDrv && ldNegOut == ldNegDrv, "R9",
        W'({shClkOut, ldPosOut, ldNegOut}), W'({shClkDrv, ldPosDrv, ldNegDrv}));
  endtask

  // Driver: one shift-clock period, pushing the expected serial output.
  task automatic shiftBit(input logic b);
    logic e;
    serDrv = b;
    idle(4);
    shClkDrv = 1'b1;
    idle(8);
    chk(serOut == prevSer, "R5 no change on rising edge", W'(serOut), W'(prevSer));
    idle(12);
    if (dirDrv) mdl = {mdl[W-2:0], b};
    else        mdl = {b, mdl[W-1:1]};
    e = dirDrv ? mdl[W-1] : mdl[0];
    expQ.push_back(e);
    prevSer = e;
    shClkDrv = 1'b0;
    idle(20);
  endtask

  // Monitor: compare serOut after each falling shift-clock edge.
  initial begin
    forever begin
      @(negedge shClkDrv);
      if (!rstDrv && expQ.size() > 0) begin
        logic e;
        idle(8);
        e = expQ.pop_front();
        chk(serOut == e, "R5 retimed serial output", W'(serOut), W'(e));
      end
    end
  end

  initial begin
    #(20ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    patA = mkPat(32'h1234_5678);
    patB = mkPat(32'h9e37_79b9);
    patC = mkPat(32'hc0de_0421);
    rstDrv = 1'b1; dirDrv = 1'b0; shClkDrv = 1'b0; serDrv = 1'b0;
    ldPosDrv = 1'b0; ldNegDrv = 1'b1;
    mdl = '0; prevSer = 1'b0;
    idle(5);
    chk(frameOut == '0, "R1 frame zero in reset", frameOut, '0);
    chk(serOut == 1'b0, "R1 serOut zero in reset", W'(serOut), '0);

    // R2: edges while reset is high, then release with levels held.
    serDrv = 1'b1;
    shClkDrv = 1'b1; chkFwd(); idle(6);
    shClkDrv = 1'b0; idle(6);
    ldPosDrv = 1'b1; chkFwd(); idle(6);
    ldPosDrv = 1'b0; ldNegDrv = 1'b0; chkFwd(); idle(6);
    shClkDrv = 1'b1; ldPosDrv = 1'b1; idle(6);
    rstDrv = 1'b0;
    idle(20);
    expQ.push_back(1'b0);
    shClkDrv = 1'b0; ldPosDrv = 1'b0; ldNegDrv = 1'b1;
    idle(20);
    chk(frameOut == '0, "R2 no load from leftover levels", frameOut, '0);
    ldNegDrv = 1'b0; idle(20);
    ldNegDrv = 1'b1; idle(20);
    chk(frameOut == '0, "R2 no shift from leftover level", frameOut, '0);

    // R3 / R6: forward direction, positive strobe.
    for (int k = 0; k < W; k++) shiftBit(patA[k]);
    ldPosDrv = 1'b1; chkFwd(); idle(20);
    chk(frameOut == patA, "R3 R6 forward frame on positive strobe", frameOut, patA);
    for (int k = 0; k < 8; k++) shiftBit(patB[k]);
    ldPosDrv = 1'b0; chkFwd(); idle(20);
    chk(frameOut == patA, "R6 R8 falling positive strobe ignored", frameOut, patA);

    // R7: negative strobe loads on its falling edge.
    snap = mdl;
    ldNegDrv = 1'b0; chkFwd(); idle(20);
    chk(frameOut == snap, "R7 negative strobe loads", frameOut, snap);
    for (int k = 8; k < 16; k++) shiftBit(patB[k]);
    ldNegDrv = 1'b1; chkFwd(); idle(20);
    chk(frameOut == snap, "R7 R8 rising negative strobe ignored", frameOut, snap);

    // R1 again mid-operation, then R4: reverse direction.
    rstDrv = 1'b1; idle(4);
    chk(frameOut == '0, "R1 reset clears frame", frameOut, '0);
    chk(serOut == 1'b0, "R1 reset clears serOut", W'(serOut), '0);
    expQ.delete();
    mdl = '0; prevSer = 1'b0;
    dirDrv = 1'b1;
    idle(4);
    rstDrv = 1'b0;
    idle(20);
    for (int k = 0; k < W; k++) shiftBit(patC[k]);
    for (int k = 0; k < W; k++) expF[W-1-k] = patC[k];
    ldNegDrv = 1'b0; idle(20);
    ldNegDrv = 1'b1; idle(20);
    chk(frameOut == expF, "R4 reverse frame on negative strobe", frameOut, expF);
    ldPosDrv = 1'b1; idle(20);
    ldPosDrv = 1'b0; idle(20);
    chk(frameOut == expF, "R4 R6 reverse frame on positive strobe", frameOut, expF);

    // R5: push the reverse frame out and see it leave in entry order.
    for (int k = 0; k < 40; k++) shiftBit(patA[k]);
    chk(frameOut == expF, "R8 frame held during shifting", frameOut, expF);
    idle(10);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule